// File: doc/BRIEF.md
# HDLC Frame Receiver

This block turns a serial HDLC bit stream, presented one bit per enable strobe, into bytes held in a receive FIFO for a host. It stays idle until it sees a flag. It aligns the following bits into bytes, least significant bit first. It strips the zero inserted after every run of five ones and checks each frame's CRC-16 frame check sequence. Runs of seven ones are treated as an abort.

The two frame check bytes are never stored. The final data byte of each frame is written with an end-of-frame tag and a two-bit status, so that a host reading the FIFO can delimit frames and judge them. The FIFO holds 64 entries, enough for a complete performance report message without host service during reception. Frames too short to carry data are dropped without a trace. A frame that meets a nearly full FIFO is cut short with an overrun status.

Top module: `hdlc_frame_receiver`

## Requirements
- R1: After reset the FIFO is empty (`fifo_empty`=1, `fifo_full`=0, `fifo_level`=0) and the receiver is hunting for a flag.
- R2: Bits before the first flag (line pattern 0,1,1,1,1,1,1,0 in arrival order) produce no FIFO entry. After a flag, received bits are packed into bytes with the first bit received in bit 0.
- R3: A 0 that arrives directly after five consecutive 1s is removed from the data and is not counted as a data bit.
- R4: The CRC is computed LSB-first with the reflected polynomial 0x8408 and seed 0xFFFF, over the data bytes and the two FCS bytes. A closing flag with residue 0xF0B8 and a whole number of bytes gives status 00 (good); any other case gives status 01 (CRC error). The FCS bytes are never written to the FIFO.
- R5: Each FIFO entry is {`rd_eof`, `rd_status`, `rd_data`}. Every byte except the last of a frame has `rd_eof`=0 and `rd_status`=00. The last stored byte has `rd_eof`=1.
- R6: Seven consecutive 1s abort the frame. If four or more bytes were received, the last pending data byte is written with `rd_eof`=1 and status 10. The receiver then hunts for a flag and ignores all bits until one arrives.
- R7: A frame with fewer than four bytes between flags, FCS included, writes nothing. This covers idle back-to-back flags.
- R8: One flag may close a frame and open the next.
- R9: If a non-final data byte must be stored while the FIFO holds 63 entries, it is written with `rd_eof`=1 and status 11 (overrun), and bits are dropped until the next flag. If the FIFO is full when a frame's first byte is due, the whole frame is dropped.
- R10: The FIFO holds 64 entries. `rd_data`/`rd_eof`/`rd_status` show the oldest entry, `rd_en` removes it, `rd_en` on an empty FIFO has no effect, and `fifo_level` counts the entries.
- R11: `bit_in` is sampled only in cycles where `bit_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Strobe: `bit_in` is valid this cycle |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| rd_data | output | 8 | Oldest entry data byte |
| rd_eof | output | 1 | Oldest entry is the last byte of a frame |
| rd_status | output | 2 | Frame status on the last byte: 00 good, 01 CRC error, 10 abort, 11 overrun |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds 64 entries |
| fifo_level | output | 7 | Number of entries in the FIFO |

## Verification
The assertions assume `bit_en` is a single-cycle strobe whose bit is stable for that cycle. They also assume `rst_n` is held long enough for the two-stage release to complete. They rely on the deframer never writing a byte without a strobe, and on the FIFO reservation keeping one slot free for a frame's closing entry. The stimulus inserts zero to two idle cycles between strobes and randomises `bit_in` while the strobe is low. It only reads the FIFO between frames, so the expected contents can be modelled from the fill level at each write.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int BYTE_W          = 8;
  localparam int ENTRY_W         = BYTE_W + 3;
  localparam int MIN_FRAME_BYTES = 4;

  localparam logic [15:0] CRC_SEED    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_RV = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {
    ST_GOOD    = 2'b00,
    ST_CRC     = 2'b01,
    ST_ABORT   = 2'b10,
    ST_OVERRUN = 2'b11
  } rx_status_e;

  typedef struct packed {
    logic              eof;
    rx_status_e        status;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

endpackage

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16
  import hdlc_rx_pkg::*;
(
  input  logic [15:0]       crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [15:0]       crc_out
);

  // Reflected CRC-16: one byte, LSB first, unrolled over the byte width.
  always_comb begin
    logic [15:0] acc;
    acc = crc_in;
    for (int i = 0; i < BYTE_W; i++) begin
      if (acc[0] ^ byte_in[i]) acc = (acc >> 1) ^ CRC_POLY_RV;
      else                     acc = acc >> 1;
    end
    crc_out = acc;
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             wr_en,
  output rx_entry_t        wr_entry
);

  typedef enum logic {S_HUNT, S_FRAME} rx_state_e;

  localparam int               CNT_W     = $clog2(MIN_FRAME_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(MIN_FRAME_BYTES);
  localparam logic [CNT_W-1:0] CNT_EMIT  = CNT_W'(MIN_FRAME_BYTES - 1);
  localparam int               BIT_W     = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BYTE_W - 1);
  // Flag's leading 0 and five 1s enter the shifter before the flag is known.
  localparam logic [BIT_W-1:0] BIT_ALIGN = BIT_W'(BYTE_W - 2);
  localparam logic [LVL_W-1:0] LVL_LAST  = LVL_W'(DEPTH - 1);

  rx_state_e         state_q, state_d;
  logic [2:0]        ones_q, ones_d;
  logic [BYTE_W-2:0] sr_q, sr_d;
  logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] pend_q, pend_d, hold1_q, hold1_d, hold0_q, hold0_d;
  logic [15:0]       crc_q, crc_d, crc_nxt;

  logic              flag_hit, abort_hit, take_bit;
  logic [BYTE_W-1:0] byte_new;

  assign flag_hit  = bit_en && !bit_in && (ones_q == 3'd6);
  assign abort_hit = bit_en &&  bit_in && (ones_q == 3'd6);
  assign take_bit  = bit_en && (state_q == S_FRAME) && (ones_q < 3'd5);
  assign byte_new  = {bit_in, sr_q};

  hdlc_rx_crc16 u_crc (
    .crc_in  (crc_q),
    .byte_in (byte_new),
    .crc_out (crc_nxt)
  );

  always_comb begin
    state_d  = state_q;
    sr_d     = sr_q;
    bitcnt_d = bitcnt_q;
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    hold1_d  = hold1_q;
    hold0_d  = hold0_q;
    crc_d    = crc_q;
    wr_en    = 1'b0;
    wr_entry = '{eof: 1'b0, status: ST_GOOD, data: pend_q};

    ones_d = ones_q;
    if (bit_en) begin
      if (!bit_in)              ones_d = 3'd0;
      else if (ones_q != 3'd7)  ones_d = ones_q + 3'd1;
    end

    if (flag_hit && state_q == S_HUNT) begin
      state_d  = S_FRAME;
      bitcnt_d = '0;
      cnt_d    = '0;
      crc_d    = CRC_SEED;
    end else if (state_q == S_FRAME) begin
      if (flag_hit) begin
        if (cnt_q == CNT_FULL) begin
          wr_en           = 1'b1;
          wr_entry.eof    = 1'b1;
          wr_entry.status = (bitcnt_q == BIT_ALIGN && crc_q == CRC_RESIDUE) ? ST_GOOD : ST_CRC;
        end
        bitcnt_d = '0;
        cnt_d    = '0;
        crc_d    = CRC_SEED;
      end else if (abort_hit) begin
        if (cnt_q == CNT_FULL) begin
          wr_en           = 1'b1;
          wr_entry.eof    = 1'b1;
          wr_entry.status = ST_ABORT;
        end
        state_d = S_HUNT;
      end else if (take_bit) begin
        sr_d     = {bit_in, sr_q[BYTE_W-2:1]};
        bitcnt_d = bitcnt_q + 1'b1;
        if (bitcnt_q == BIT_LAST) begin
          crc_d   = crc_nxt;
          hold0_d = byte_new;
          hold1_d = hold0_q;
          pend_d  = hold1_q;
          if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
          if (cnt_q >= CNT_EMIT) begin
            if (fifo_level < LVL_LAST) begin
              wr_en = 1'b1;
            end else if (fifo_level == LVL_LAST) begin
              wr_en           = 1'b1;
              wr_entry.eof    = 1'b1;
              wr_entry.status = ST_OVERRUN;
              state_d         = S_HUNT;
            end else begin
              state_d = S_HUNT;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_HUNT;
      ones_q   <= '0;
      sr_q     <= '0;
      bitcnt_q <= '0;
      cnt_q    <= '0;
      pend_q   <= '0;
      hold1_q  <= '0;
      hold0_q  <= '0;
      crc_q    <= CRC_SEED;
    end else begin
      state_q  <= state_d;
      ones_q   <= ones_d;
      sr_q     <= sr_d;
      bitcnt_q <= bitcnt_d;
      cnt_q    <= cnt_d;
      pend_q   <= pend_d;
      hold1_q  <= hold1_d;
      hold0_q  <= hold0_d;
      crc_q    <= crc_d;
    end
  end

  AST_ABORT_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q == 3'd7) |-> (state_q == S_HUNT)); // R6
  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HUNT) |-> !wr_en); // R2

endmodule

// File: rtl/hdlc_rx_fifo_buf.sv
module hdlc_rx_fifo_buf #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 11,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [LVL_W-1:0] count,
  output logic             empty,
  output logic             full
);

  localparam int               AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    PTR_END = AW'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] count_q, count_d;
  logic             do_wr, do_rd;

  assign empty   = (count_q == '0);
  assign full    = (count_q == LVL_MAX);
  assign count   = count_q;
  assign rd_data = mem[rd_ptr_q];
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (do_wr) wr_ptr_d = (wr_ptr_q == PTR_END) ? '0 : wr_ptr_q + 1'b1;
    if (do_rd) rd_ptr_d = (rd_ptr_q == PTR_END) ? '0 : rd_ptr_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data;
  end

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (count_q == '0)); // R10
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q > $past(count_q)) |-> (count_q == $past(count_q) + 1'b1)); // R10

endmodule

// File: rtl/hdlc_frame_receiver.sv
module hdlc_frame_receiver
  import hdlc_rx_pkg::*;
#(
  parameter  int FIFO_DEPTH = 64,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_eof,
  output logic [1:0]        rd_status,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [LVL_W-1:0]  fifo_level
);

  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(FIFO_DEPTH - 1);

  logic [1:0]         rst_pipe_q;
  logic               rst_core_n;
  logic               df_wr_en;
  rx_entry_t          df_entry;
  logic [ENTRY_W-1:0] head_word;
  rx_entry_t          head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  hdlc_rx_deframer #(
    .DEPTH (FIFO_DEPTH),
    .LVL_W (LVL_W)
  ) u_deframer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .fifo_level (fifo_level),
    .wr_en      (df_wr_en),
    .wr_entry   (df_entry)
  );

  hdlc_rx_fifo_buf #(
    .DEPTH (FIFO_DEPTH),
    .WIDTH (ENTRY_W),
    .LVL_W (LVL_W)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (df_wr_en),
    .wr_data (df_entry),
    .rd_en   (rd_en),
    .rd_data (head_word),
    .count   (fifo_level),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  assign head      = head_word;
  assign rd_data   = head.data;
  assign rd_eof    = head.eof;
  assign rd_status = head.status;

  AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_core_n)
    df_wr_en |-> !fifo_full); // R9
  AST_DATA_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (df_wr_en && !df_entry.eof) |-> (fifo_level < LVL_LAST)); // R9
  AST_TAG_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_core_n)
    (df_wr_en && !df_entry.eof) |-> (df_entry.status == ST_GOOD)); // R5
  AST_WRITE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_core_n)
    df_wr_en |-> bit_en); // R11

endmodule

// File: tb/hdlc_frame_receiver_tb_top.sv
module hdlc_frame_receiver_tb_top;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n, bit_en, bit_in, rd_en;
  logic [7:0] rd_data;
  logic       rd_eof, fifo_empty, fifo_full;
  logic [1:0] rd_status;
  logic [6:0] fifo_level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int tx_ones = 0;

  logic [7:0]  frm [0:127];
  logic [10:0] exp_q [$];

  always #4 clk = ~clk;

  hdlc_frame_receiver #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_eof     (rd_eof),
    .rd_status  (rd_status),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) r = (r[0] ^ b[k]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic string tag_of(input logic [10:0] e);
    if (!e[10]) return "R5 R3 R11 data";
    case (e[9:8])
      2'b00:   return "R4 R8 good end";
      2'b01:   return "R4 crc end";
      2'b10:   return "R6 abort end";
      default: return "R9 overrun end";
    endcase
  endfunction

  // One strobed bit; random idle gap with junk on bit_in (R11)
  task automatic send_raw(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = 1'($urandom & 1);
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic send_data_bit(input logic b);
    send_raw(b);
    tx_ones = b ? tx_ones + 1 : 0;
    if (tx_ones == 5) begin
      send_raw(1'b0);
      tx_ones = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_data_bit(b[i]);
  endtask

  task automatic send_flag();
    logic [7:0] f;
    f = 8'h7E;
    for (int i = 0; i < 8; i++) send_raw(f[i]);
    tx_ones = 0;
  endtask

  task automatic send_abort();
    for (int i = 0; i < 7; i++) send_raw(1'b1);
    tx_ones = 0;
  endtask

  task automatic send_payload(input int n);
    for (int i = 0; i < n; i++) send_byte(frm[i]);
  endtask

  task automatic send_fcs(input int n, input bit corrupt);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) c = fcs_step(c, frm[i]);
    c = ~c;
    if (corrupt) c = c ^ 16'h0100;
    send_byte(c[7:0]);
    send_byte(c[15:8]);
  endtask

  // Expected FIFO contents for a frame with n stored-candidate data bytes
  task automatic model_frame(input int n, input logic [1:0] fin);
    if (n < 2) return;
    for (int i = 0; i < n; i++) begin
      if (i < n - 1) begin
        if (exp_q.size() < DEPTH - 1) exp_q.push_back({1'b0, 2'b00, frm[i]});
        else begin
          if (exp_q.size() == DEPTH - 1) exp_q.push_back({1'b1, 2'b11, frm[i]});
          return;
        end
      end else begin
        exp_q.push_back({1'b1, fin, frm[i]});
      end
    end
  endtask

  task automatic drain();
    @(negedge clk);
    chk(fifo_level == 7'(exp_q.size()), "R10 level before drain", fifo_level, exp_q.size());
    while (exp_q.size() > 0) begin
      logic [10:0] e;
      e = exp_q.pop_front();
      @(negedge clk);
      chk(!fifo_empty, "R10 entry present", fifo_empty, 0);
      chk({rd_eof, rd_status, rd_data} == e, tag_of(e), {rd_eof, rd_status, rd_data}, e);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
    @(negedge clk);
    chk(fifo_empty && fifo_level == 0, "R10 empty after drain", fifo_level, 0);
  endtask

  task automatic good_frame(input int n, input bit corrupt);
    send_payload(n);
    send_fcs(n, corrupt);
    send_flag();
    model_frame(n, corrupt ? 2'b01 : 2'b00);
  endtask

  initial begin
    void'($urandom(32'h1D5C));
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; rd_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);
    chk(fifo_level == 0, "R1 level", fifo_level, 0);

    // R10 read on empty FIFO
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk(fifo_level == 0 && fifo_empty, "R10 read on empty", fifo_level, 0);

    // R2 stuffed garbage before any flag
    for (int i = 0; i < 6; i++) send_byte(8'($urandom));
    send_flag();
    @(negedge clk);
    chk(fifo_level == 0, "R2 no entry before flag", fifo_level, 0);

    // R3 directed stuffing patterns, R8 shared closing flag
    frm[0] = 8'hFF; frm[1] = 8'h7E; frm[2] = 8'h3E; frm[3] = 8'hF8; frm[4] = 8'h1F;
    good_frame(5, 1'b0);
    frm[0] = 8'hA5; frm[1] = 8'h5A; frm[2] = 8'hFF;
    good_frame(3, 1'b0);
    drain();

    // R7 short frames and idle flags
    frm[0] = 8'h42;
    good_frame(1, 1'b0);
    send_payload(0); send_fcs(0, 1'b0); send_flag();
    send_flag(); send_flag();
    @(negedge clk);
    chk(fifo_level == 0, "R7 short frames dropped", fifo_level, 0);
    frm[0] = 8'h12; frm[1] = 8'h34;
    good_frame(2, 1'b0);
    drain();

    // R6 directed abort with five bytes received
    for (int i = 0; i < 5; i++) frm[i] = 8'(8'h10 + i);
    send_payload(5); send_abort();
    for (int i = 0; i < 3; i++) send_byte(8'($urandom));
    send_flag();
    model_frame(3, 2'b10);
    drain();

    // Random mix of good, CRC error and aborted frames
    for (int f = 0; f < 32; f++) begin
      int kind;
      int n;
      kind = int'($urandom % 3);
      n    = 1 + int'($urandom % 10);
      for (int i = 0; i < n; i++) frm[i] = 8'($urandom);
      if (kind == 2) begin
        send_payload(n);
        send_abort();
        send_flag();
        model_frame(n - 2, 2'b10);
      end else begin
        good_frame(n, kind == 1);
      end
      repeat ($urandom % 3) send_flag();
      if (f % 4 == 3) drain();
    end

    // R9 overrun: no reads during a long frame
    for (int i = 0; i < 70; i++) frm[i] = 8'($urandom);
    good_frame(70, 1'b0);
    @(negedge clk);
    chk(fifo_full == 1'b1, "R9 full after overrun", fifo_full, 1);
    chk(fifo_level == 7'd64, "R9 level after overrun", fifo_level, 64);
    for (int i = 0; i < 5; i++) frm[i] = 8'($urandom);
    good_frame(5, 1'b0);
    @(negedge clk);
    chk(fifo_level == 7'd64, "R9 frame dropped while full", fifo_level, 64);
    drain();
    for (int i = 0; i < 6; i++) frm[i] = 8'($urandom);
    good_frame(6, 1'b0);
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule